// File: doc/BRIEF.md
# Programmable Product-Term Array with Per-Term Disable

This block is the AND plane and first OR stage of a small sum-of-products logic device. It takes twenty logic signals, which are the device's input pins plus the feedback taps from its output cells. From each signal it forms a true column and an inverted column, for forty columns in all. Sixty-four product terms are built from a programmed column mask. The terms are split into eight groups of eight, one group for each output cell. Each group produces an OR sum and also brings out its first term on its own wire, so that the output cell can use that term as an output enable.

Every term carries its own kill bit. A set kill bit forces the term low whatever its column mask says. The whole configuration, masks and kill bits together, is loaded serially into a staging chain. It changes the logic only when a commit strobe copies the chain into the active image. The sums and the enable terms are registered and appear one clock after the inputs that produced them. Output cell logic is not part of this block.

Top module: `pterm_array`

## Requirements
- R1: A synchronous active-high reset clears `sum_out` and `oe_term` to zero. It also loads an active image in which every term is killed, so both outputs stay zero for any `sig_in` until the first commit.
- R2: Column 2k carries `sig_in[k]` and column 2k+1 carries its inverse. A mask bit of 1 connects that column to the term. A live term is 1 exactly when every connected column is 1.
- R3: A live term with no connected columns evaluates to 1.
- R4: A term whose kill bit is 1 is 0, both in its group's sum and on the enable output.
- R5: Output o owns terms 8o to 8o+7, and `sum_out[o]` is the OR of those terms.
- R6: `oe_term[o]` equals term 8o, the first term of group o, whatever `first_as_oe` says.
- R7: When `first_as_oe[o]` is 1, term 8o is left out of `sum_out[o]`. The other seven terms of the group are still ORed in.
- R8: The staging chain takes one bit per clock on `cfg_data` while `cfg_shift_en` is 1, most significant bit first. The image is 64 rows of 41 bits, row 63 first. Within a row, bit 40 is the kill bit and bits 39..0 are the column mask, with bit c for column c. Row 63 bit 40 is the first bit shifted in, and row 0 bit 0 is the last.
- R9: Shifting changes nothing at the outputs. A one-cycle `cfg_commit` copies the staging chain, as it stood before that edge, into the active image.
- R10: The outputs are registered. A change on `sig_in` or `first_as_oe` shows at the outputs after the next rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the array registers and the configuration chain |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 20 | Device inputs and cell feedbacks feeding the columns |
| cfg_shift_en | input | 1 | Shift one configuration bit into the staging chain |
| cfg_data | input | 1 | Serial configuration bit |
| cfg_commit | input | 1 | Copy the staging chain into the active image |
| first_as_oe | input | 8 | Per group: drop the first term from the sum |
| sum_out | output | 8 | Registered OR sum for each group |
| oe_term | output | 8 | Registered first term of each group |

## Verification
The bench first goes after terms with no connected columns. A design that treated an empty mask as "no match" would hold its sums low when they should be high. It then checks terms that are killed but would otherwise fire. If the kill bit reached only the OR and not the enable wire, `oe_term` would go high wrongly. A one-hot pattern on signal 0 shows whether the column order is swapped or the rows are packed the wrong way round. In that case the wrong output bit, or the inverted one, lights up. The bench also shifts a full new image without a commit, to catch a design that lets staged bits leak into the live logic. Finally, it toggles `first_as_oe` with only the first term live, which exposes a sum that ignores the drop control. Random sparse masks with random kill bits then sweep the remaining combinations against a model built from the requirements.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int SIG_COUNT_DEF   = 20;
  localparam int GROUP_COUNT_DEF = 8;
  localparam int TERMS_PER_DEF   = 8;

  // Least significant bit of a configuration row within the flat image.
  function automatic int row_lsb(input int row, input int row_bits);
    return row * row_bits;
  endfunction
endpackage

// File: rtl/pta_cfg_chain.sv
module pta_cfg_chain #(
  parameter int TERM_COUNT = 64,
  parameter int COL_COUNT  = 40,
  localparam int ROW_BITS  = COL_COUNT + 1,
  localparam int IMG_BITS  = TERM_COUNT * ROW_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                shift_bit,
  input  logic                commit,
  output logic [IMG_BITS-1:0] active_img
);
  function automatic logic [IMG_BITS-1:0] killed_image();
    logic [IMG_BITS-1:0] img;
    img = '0;
    for (int r = 0; r < TERM_COUNT; r++) img[r*ROW_BITS + COL_COUNT] = 1'b1;
    return img;
  endfunction

  localparam logic [IMG_BITS-1:0] RESET_IMG = killed_image();

  logic [IMG_BITS-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (shift_en) begin
      stage_q <= {stage_q[IMG_BITS-2:0], shift_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_img <= RESET_IMG;
    end else if (commit) begin
      active_img <= stage_q;
    end
  end

  // R8
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> stage_q[0] == $past(shift_bit));

  // R9
  hold_img_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(active_img));
endmodule

// File: rtl/pta_term.sv
module pta_term #(
  parameter int COL_COUNT = 40
) (
  input  logic [COL_COUNT-1:0] cols,
  input  logic [COL_COUNT-1:0] mask,
  input  logic                 kill,
  output logic                 hit
);
  logic [COL_COUNT-1:0] col_ok;

  // A column is satisfied when unconnected or when it is high.
  always_comb begin
    col_ok = cols | ~mask;
    hit    = !kill && (&col_ok);
  end
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
  parameter int TERMS_PER = 8
) (
  input  logic [TERMS_PER-1:0] terms,
  input  logic                 drop_first,
  output logic                 sum,
  output logic                 first_term
);
  logic [TERMS_PER-1:0] keep;

  always_comb begin
    keep    = '1;
    keep[0] = !drop_first;
    sum        = |(terms & keep);
    first_term = terms[0];
  end
endmodule

// File: rtl/pterm_array.sv
module pterm_array #(
  parameter int SIG_COUNT   = pta_pkg::SIG_COUNT_DEF,
  parameter int GROUP_COUNT = pta_pkg::GROUP_COUNT_DEF,
  parameter int TERMS_PER   = pta_pkg::TERMS_PER_DEF,
  localparam int COL_COUNT  = 2 * SIG_COUNT,
  localparam int TERM_COUNT = GROUP_COUNT * TERMS_PER,
  localparam int ROW_BITS   = COL_COUNT + 1,
  localparam int IMG_BITS   = TERM_COUNT * ROW_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SIG_COUNT-1:0]   sig_in,
  input  logic                   cfg_shift_en,
  input  logic                   cfg_data,
  input  logic                   cfg_commit,
  input  logic [GROUP_COUNT-1:0] first_as_oe,
  output logic [GROUP_COUNT-1:0] sum_out,
  output logic [GROUP_COUNT-1:0] oe_term
);
  logic [IMG_BITS-1:0]    active_img;
  logic [COL_COUNT-1:0]   cols;
  logic [TERM_COUNT-1:0]  term_hit;
  logic [GROUP_COUNT-1:0] sum_d;
  logic [GROUP_COUNT-1:0] oe_d;

  pta_cfg_chain #(
    .TERM_COUNT(TERM_COUNT),
    .COL_COUNT (COL_COUNT)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (cfg_shift_en),
    .shift_bit (cfg_data),
    .commit    (cfg_commit),
    .active_img(active_img)
  );

  // Column pairs: even = true, odd = inverted.
  for (genvar k = 0; k < SIG_COUNT; k++) begin : g_col
    assign cols[2*k]   = sig_in[k];
    assign cols[2*k+1] = ~sig_in[k];
  end

  for (genvar t = 0; t < TERM_COUNT; t++) begin : g_term
    localparam int LSB = pta_pkg::row_lsb(t, ROW_BITS);
    pta_term #(.COL_COUNT(COL_COUNT)) u_term (
      .cols(cols),
      .mask(active_img[LSB +: COL_COUNT]),
      .kill(active_img[LSB + COL_COUNT]),
      .hit (term_hit[t])
    );
  end

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : g_grp
    pta_or_plane #(.TERMS_PER(TERMS_PER)) u_or (
      .terms     (term_hit[g*TERMS_PER +: TERMS_PER]),
      .drop_first(first_as_oe[g]),
      .sum       (sum_d[g]),
      .first_term(oe_d[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out <= '0;
      oe_term <= '0;
    end else begin
      sum_out <= sum_d;
      oe_term <= oe_d;
    end
  end

  // R1
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sum_out == '0 && oe_term == '0));

  // R7
  first_in_sum_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((oe_term & ~$past(first_as_oe) & ~sum_out) == '0));
endmodule

// File: tb/pterm_array_test.sv
`timescale 1ns/1ps
module pterm_array_test;
  localparam int NS = 20;
  localparam int NG = 8;
  localparam int TP = 8;
  localparam int NC = 2 * NS;
  localparam int NT = NG * TP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] sig_in = '0;
  logic          cfg_shift_en = 1'b0;
  logic          cfg_data = 1'b0;
  logic          cfg_commit = 1'b0;
  logic [NG-1:0] first_as_oe = '0;
  logic [NG-1:0] sum_out;
  logic [NG-1:0] oe_term;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NC-1:0] m_mask [NT];
  logic          m_kill [NT];

  always #2 clk = ~clk;

  pterm_array uut (
    .clk(clk), .rst(rst), .sig_in(sig_in),
    .cfg_shift_en(cfg_shift_en), .cfg_data(cfg_data), .cfg_commit(cfg_commit),
    .first_as_oe(first_as_oe), .sum_out(sum_out), .oe_term(oe_term)
  );

  task automatic check(input string req, input logic [NG-1:0] act, input logic [NG-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic term_val(input int t, input logic [NS-1:0] s);
    logic v;
    v = !m_kill[t];
    for (int c = 0; c < NC; c++) begin
      logic colv;
      colv = (c % 2 == 0) ? s[c/2] : !s[c/2];
      if (m_mask[t][c] && !colv) v = 1'b0;
    end
    return v;
  endfunction

  function automatic logic [NG-1:0] exp_sum(input logic [NS-1:0] s, input logic [NG-1:0] drop);
    logic [NG-1:0] r;
    r = '0;
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < TP; i++)
        if (!(i == 0 && drop[g]) && term_val(g*TP + i, s)) r[g] = 1'b1;
    return r;
  endfunction

  function automatic logic [NG-1:0] exp_oe(input logic [NS-1:0] s);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = term_val(g*TP, s);
    return r;
  endfunction

  // Shift the model image in, row NT-1 kill bit first (R8).
  task automatic shift_image();
    for (int r = NT - 1; r >= 0; r--)
      for (int b = NC; b >= 0; b--) begin
        @(negedge clk);
        cfg_shift_en = 1'b1;
        cfg_data = (b == NC) ? m_kill[r] : m_mask[r][b];
      end
    @(negedge clk);
    cfg_shift_en = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  task automatic apply(input logic [NS-1:0] s, input logic [NG-1:0] d);
    @(negedge clk);
    sig_in = s;
    first_as_oe = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input logic kill, input logic [NC-1:0] mask);
    for (int t = 0; t < NT; t++) begin
      m_kill[t] = kill;
      m_mask[t] = mask;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset sums", sum_out, 8'h00);
    check("R1 reset enables", oe_term, 8'h00);
    rst = 1'b0;
    apply(20'hFFFFF, 8'h00);
    check("R1 killed before commit sums", sum_out, 8'h00);
    check("R1 killed before commit enables", oe_term, 8'h00);

    // R3: every term live and empty
    fill(1'b0, '0);
    shift_image();
    commit();
    apply(20'h12345, 8'h00);
    check("R3 empty terms sum", sum_out, 8'hFF);
    check("R3 empty terms enable", oe_term, 8'hFF);
    apply(20'h00000, 8'hFF);
    check("R7 other terms keep sum", sum_out, 8'hFF);
    check("R6 enable ignores drop", oe_term, 8'hFF);

    // R4: all killed, empty masks
    fill(1'b1, '0);
    shift_image();
    commit();
    apply(20'hABCDE, 8'h00);
    check("R4 killed sums", sum_out, 8'h00);
    check("R4 killed enables", oe_term, 8'h00);

    // R7: only first term of each group live
    fill(1'b1, '0);
    for (int g = 0; g < NG; g++) m_kill[g*TP] = 1'b0;
    shift_image();
    commit();
    apply(20'h0, 8'h00);
    check("R7 first term counted", sum_out, 8'hFF);
    apply(20'h0, 8'hA5);
    check("R7 first term dropped", sum_out, 8'h5A);
    check("R6 enable with drop", oe_term, 8'hFF);

    // R2/R8: term 0 on column 0, term 8 on column 1, rest killed
    fill(1'b1, '0);
    m_kill[0] = 1'b0; m_mask[0] = 40'h1;
    m_kill[TP] = 1'b0; m_mask[TP] = 40'h2;
    shift_image();
    commit();
    apply(20'h00001, 8'h00);
    check("R2 true column", sum_out, 8'h01);
    check("R6 group enables", oe_term, 8'h01);
    @(negedge clk);
    sig_in = 20'h00000;
    #1;
    check("R10 no change before edge", sum_out, 8'h01);
    @(posedge clk);
    @(negedge clk);
    check("R2 inverted column", sum_out, 8'h02);
    check("R8 row order enable", oe_term, 8'h02);

    // R9: staged image does nothing until commit
    fill(1'b0, '0);
    shift_image();
    apply(20'h00001, 8'h00);
    check("R9 staging has no effect", sum_out, 8'h01);
    commit();
    apply(20'h00001, 8'h00);
    check("R9 commit applies image", sum_out, 8'hFF);

    // Random sparse patterns (R2 R4 R5 R6 R7)
    for (int p = 0; p < 8; p++) begin
      for (int t = 0; t < NT; t++) begin
        m_kill[t] = ($urandom % 4) == 0;
        m_mask[t] = '0;
        if (($urandom % 8) != 0)
          for (int c = 0; c < NC; c++) m_mask[t][c] = ($urandom % 16) == 0;
      end
      shift_image();
      commit();
      for (int v = 0; v < 40; v++) begin
        logic [NS-1:0] s;
        logic [NG-1:0] d;
        s = NS'($urandom);
        d = NG'($urandom);
        apply(s, d);
        check("R5 random sum", sum_out, exp_sum(s, d));
        check("R6 random enable", oe_term, exp_oe(s));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule